// File: doc/BRIEF.md
# Banked Channel Limit Monitor

The block watches a set of measurement channels and raises events when a reading leaves its allowed window. Samples arrive on a streaming input, each tagged with a channel number. When the channel is enabled and monitoring is switched on, the sample is stored as that channel's latest reading. In the same cycle it is compared against the channel's high, low and critical limits. A reading outside the high/low window latches a per-channel event bit. A reading above the critical limit latches a separate critical bit.

All per-channel state sits behind one bank-select register. Software writes a channel number there, and the enable, reading and limit registers of that channel then appear at fixed offsets. Event bits are cleared by writing 1. They feed two separately maskable interrupt outputs, one for management events and one for ordinary interrupts. Critical bits drive an unmasked alert.

The parameters select one of two builds. One is a temperature build with three channels and signed comparisons. The other is a voltage build with fourteen channels and unsigned comparisons. At most 16 channels are supported. No converter and no value scaling are included.

Top module: `bank_limit_mon`

## Requirements
- R1: After reset, every status, mask, global configuration, bank-select and channel-enable register reads 0, and smi_o, irq_o and crit_o are low.
- R2: Offset 0x09 holds the bank number. Offsets 0x0A to 0x0E address the channel with that number. While the bank number is not below NCH, those offsets read 0 and writes to them change nothing.
- R3: Bit 0 of offset 0x0A enables the selected channel, and bit 0 of offset 0x08 enables monitoring globally. A sample is discarded when its channel is disabled, when monitoring is off, or when the channel index is not below NCH. A discarded sample leaves both the reading and the status unchanged.
- R4: An accepted sample becomes the channel's reading on the same clock edge and can be read at offset 0x0B from the next cycle.
- R5: On the edge that stores a reading above the high limit (0x0C) or below the low limit (0x0D), channel i's status bit is set. That bit is bit i%8 of offset 0x00 + i/8.
- R6: Comparisons are signed two's complement when SIGNED_CMP=1 and unsigned when SIGNED_CMP=0. A reading equal to a limit raises no event.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as the clearing write keeps the bit set.
- R8: smi_o is high when any status bit is set whose mask bit is set at offsets 0x02/0x03. irq_o behaves the same way with the mask at 0x04/0x05. Both follow the registers with no added delay.
- R9: On the edge that stores a reading above the critical limit (0x0E), the channel's critical bit at 0x06/0x07 is set. These bits are cleared by writing 1, and crit_o is high while any of them is set, with no mask.
- R10: At reset, the limits of each channel are the widest possible. The high and critical limits hold the largest value, and the low limit holds the smallest value of the compare mode (0x7F/0x80 signed, 0xFF/0x00 unsigned).
- R11: Unassigned offsets, and status or mask bits for channels not below NCH, read 0. Writes to unassigned offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| smp_valid | input | 1 | Sample present |
| smp_chan | input | CW | Channel of the sample |
| smp_value | input | DW | Sample value |
| smi_o | output | 1 | Management event request |
| irq_o | output | 1 | Interrupt request |
| crit_o | output | 1 | Critical-limit alert |

## Verification
The window check is driven with samples placed inside the window, exactly on each limit, and one step beyond each limit. This separates strict from inclusive comparison. Samples are also chosen whose outcome flips between signed and unsigned interpretation, for example 0x10 against a low limit of 0xF0, and 0x90 against a 0x10 to 0xA0 window. These show the compare mode of each build. Samples are also sent to a disabled channel, with monitoring off, and to an out-of-range channel index, and each must leave no trace. A clearing write coincides with a fresh event on the same channel, and masks are set for one channel while another raises the event. Together these separate the clear and set priority and the routing of each event to its output.

// File: rtl/blm_pkg.sv
package blm_pkg;
  // Register offsets of the monitor's byte-wide register window.
  localparam int OFS_STAT_LO = 'h00;
  localparam int OFS_STAT_HI = 'h01;
  localparam int OFS_SMI_LO  = 'h02;
  localparam int OFS_SMI_HI  = 'h03;
  localparam int OFS_IRQ_LO  = 'h04;
  localparam int OFS_IRQ_HI  = 'h05;
  localparam int OFS_CRIT_LO = 'h06;
  localparam int OFS_CRIT_HI = 'h07;
  localparam int OFS_GCFG    = 'h08;
  localparam int OFS_BANK    = 'h09;
  localparam int OFS_CCFG    = 'h0A;
  localparam int OFS_RDG     = 'h0B;
  localparam int OFS_HI      = 'h0C;
  localparam int OFS_LO      = 'h0D;
  localparam int OFS_OT      = 'h0E;
  // Event registers are two bytes wide.
  localparam int MAX_CH      = 16;
endpackage

// File: rtl/blm_chan.sv
module blm_chan #(
  parameter int DW         = 8,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic          ot_we,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  input  logic [DW-1:0] sample,
  output logic          en_o,
  output logic [DW-1:0] rdg_o,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] ot_o,
  output logic          range_hit_o,
  output logic          crit_hit_o
);
  localparam logic [DW-1:0] LIM_MAX = SIGNED_CMP ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  localparam logic [DW-1:0] LIM_MIN = SIGNED_CMP ? {1'b1, {(DW-1){1'b0}}} : {DW{1'b0}};

  logic          en_q;
  logic [DW-1:0] rdg_q, hi_q, lo_q, ot_q;
  logic          en_d;
  logic [DW-1:0] rdg_d, hi_d, lo_d, ot_d;
  logic          above_hi, below_lo, above_ot;

  always_comb begin
    en_d  = wdata[0];
    rdg_d = sample;
    hi_d  = wdata;
    lo_d  = wdata;
    ot_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rdg_q <= '0;
      hi_q  <= LIM_MAX;
      lo_q  <= LIM_MIN;
      ot_q  <= LIM_MAX;
    end else begin
      if (cfg_we) en_q  <= en_d;
      if (take)   rdg_q <= rdg_d;
      if (hi_we)  hi_q  <= hi_d;
      if (lo_we)  lo_q  <= lo_d;
      if (ot_we)  ot_q  <= ot_d;
    end
  end

  generate
    if (SIGNED_CMP) begin : g_signed
      always_comb begin
        above_hi = $signed(sample) > $signed(hi_q);
        below_lo = $signed(sample) < $signed(lo_q);
        above_ot = $signed(sample) > $signed(ot_q);
      end
    end else begin : g_unsigned
      always_comb begin
        above_hi = sample > hi_q;
        below_lo = sample < lo_q;
        above_ot = sample > ot_q;
      end
    end
  endgenerate

  assign range_hit_o = take & (above_hi | below_lo);
  assign crit_hit_o  = take & above_ot;
  assign en_o  = en_q;
  assign rdg_o = rdg_q;
  assign hi_o  = hi_q;
  assign lo_o  = lo_q;
  assign ot_o  = ot_q;

  // R3: a disabled channel keeps its reading
  assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(rdg_q));
endmodule

// File: rtl/blm_events.sv
module blm_events #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_rng,
  input  logic [NCH-1:0] set_crit,
  input  logic [1:0]     wr_stat,
  input  logic [1:0]     wr_crit,
  input  logic [1:0]     wr_smi,
  input  logic [1:0]     wr_irq,
  input  logic [DW-1:0]  wdata,
  output logic [15:0]    stat_pad_o,
  output logic [15:0]    crit_pad_o,
  output logic [15:0]    smi_pad_o,
  output logic [15:0]    irq_pad_o,
  output logic           smi_o,
  output logic           irq_o,
  output logic           crit_o
);
  logic [NCH-1:0] stat_q, crit_q, smim_q, irqm_q;
  logic [NCH-1:0] stat_d, crit_d, smim_d, irqm_d;
  logic           stat_en, crit_en, smim_en, irqm_en;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      stat_d[i] = set_rng[i]  | (stat_q[i] & ~(wr_stat[i/8] & wdata[i%8]));
      crit_d[i] = set_crit[i] | (crit_q[i] & ~(wr_crit[i/8] & wdata[i%8]));
      smim_d[i] = wr_smi[i/8] ? wdata[i%8] : smim_q[i];
      irqm_d[i] = wr_irq[i/8] ? wdata[i%8] : irqm_q[i];
    end
    stat_en = (|set_rng)  | (|wr_stat);
    crit_en = (|set_crit) | (|wr_crit);
    smim_en = |wr_smi;
    irqm_en = |wr_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      crit_q <= '0;
      smim_q <= '0;
      irqm_q <= '0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (crit_en) crit_q <= crit_d;
      if (smim_en) smim_q <= smim_d;
      if (irqm_en) irqm_q <= irqm_d;
    end
  end

  always_comb begin
    stat_pad_o = '0;
    crit_pad_o = '0;
    smi_pad_o  = '0;
    irq_pad_o  = '0;
    stat_pad_o[NCH-1:0] = stat_q;
    crit_pad_o[NCH-1:0] = crit_q;
    smi_pad_o[NCH-1:0]  = smim_q;
    irq_pad_o[NCH-1:0]  = irqm_q;
  end

  assign smi_o  = |(stat_q & smim_q);
  assign irq_o  = |(stat_q & irqm_q);
  assign crit_o = |crit_q;

  // R5: a status bit only rises after a range hit on its channel
  assert_set_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(set_rng)) == '0);
  // R7: write-one clears the low status byte when no event competes
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat[0] && set_rng == '0) |=> ((stat_pad_o[7:0] & $past(wdata)) == 8'h00));
  // R8: with an empty mask the request stays low
  assert_smi_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smim_q == '0) |-> !smi_o);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqm_q == '0) |-> !irq_o);
  // R9: the alert only rises after a critical hit
  assert_crit_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crit_o) |-> $past(|set_crit));
endmodule

// File: rtl/bank_limit_mon.sv
module bank_limit_mon
  import blm_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int DW         = 8,
  parameter int AW         = 4,
  parameter bit SIGNED_CMP = 1'b1,
  localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          smp_valid,
  input  logic [CW-1:0] smp_chan,
  input  logic [DW-1:0] smp_value,
  output logic          smi_o,
  output logic          irq_o,
  output logic          crit_o
);
  logic          gen_q, gen_d, gen_en;
  logic [DW-1:0] bank_q, bank_d;
  logic          bank_en;
  logic          bank_ok;
  logic [CW-1:0] bank_idx;

  logic [NCH-1:0] ch_en, take, rng_hit, crit_hit;
  logic [NCH-1:0] cfg_we, hi_we, lo_we, ot_we;
  logic [DW-1:0]  rdg_a [NCH];
  logic [DW-1:0]  hi_a  [NCH];
  logic [DW-1:0]  lo_a  [NCH];
  logic [DW-1:0]  ot_a  [NCH];

  logic [1:0]  wr_stat, wr_crit, wr_smi, wr_irq;
  logic [15:0] stat_pad, crit_pad, smi_pad, irq_pad;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  // Global configuration and bank select
  always_comb begin
    gen_en  = bus_we & hit(bus_addr, OFS_GCFG);
    gen_d   = bus_wdata[0];
    bank_en = bus_we & hit(bus_addr, OFS_BANK);
    bank_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      bank_q <= '0;
    end else begin
      if (gen_en)  gen_q  <= gen_d;
      if (bank_en) bank_q <= bank_d;
    end
  end

  assign bank_ok  = bank_q < DW'(NCH);
  assign bank_idx = bank_q[CW-1:0];

  // Byte strobes for the two-byte event registers
  always_comb begin
    wr_stat = {bus_we & hit(bus_addr, OFS_STAT_HI), bus_we & hit(bus_addr, OFS_STAT_LO)};
    wr_crit = {bus_we & hit(bus_addr, OFS_CRIT_HI), bus_we & hit(bus_addr, OFS_CRIT_LO)};
    wr_smi  = {bus_we & hit(bus_addr, OFS_SMI_HI),  bus_we & hit(bus_addr, OFS_SMI_LO)};
    wr_irq  = {bus_we & hit(bus_addr, OFS_IRQ_HI),  bus_we & hit(bus_addr, OFS_IRQ_LO)};
  end

  // Channel slices
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel       = bank_ok & (bank_idx == CW'(c));
      assign cfg_we[c] = bus_we & sel & hit(bus_addr, OFS_CCFG);
      assign hi_we[c]  = bus_we & sel & hit(bus_addr, OFS_HI);
      assign lo_we[c]  = bus_we & sel & hit(bus_addr, OFS_LO);
      assign ot_we[c]  = bus_we & sel & hit(bus_addr, OFS_OT);
      assign take[c]   = smp_valid & gen_q & ch_en[c] & (smp_chan == CW'(c));

      blm_chan #(.DW(DW), .SIGNED_CMP(SIGNED_CMP)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we[c]),
        .hi_we       (hi_we[c]),
        .lo_we       (lo_we[c]),
        .ot_we       (ot_we[c]),
        .wdata       (bus_wdata),
        .take        (take[c]),
        .sample      (smp_value),
        .en_o        (ch_en[c]),
        .rdg_o       (rdg_a[c]),
        .hi_o        (hi_a[c]),
        .lo_o        (lo_a[c]),
        .ot_o        (ot_a[c]),
        .range_hit_o (rng_hit[c]),
        .crit_hit_o  (crit_hit[c])
      );
    end
  endgenerate

  blm_events #(.NCH(NCH), .DW(DW)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_rng    (rng_hit),
    .set_crit   (crit_hit),
    .wr_stat    (wr_stat),
    .wr_crit    (wr_crit),
    .wr_smi     (wr_smi),
    .wr_irq     (wr_irq),
    .wdata      (bus_wdata),
    .stat_pad_o (stat_pad),
    .crit_pad_o (crit_pad),
    .smi_pad_o  (smi_pad),
    .irq_pad_o  (irq_pad),
    .smi_o      (smi_o),
    .irq_o      (irq_o),
    .crit_o     (crit_o)
  );

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFS_STAT_LO: bus_rdata = stat_pad[7:0];
      OFS_STAT_HI: bus_rdata = stat_pad[15:8];
      OFS_SMI_LO:  bus_rdata = smi_pad[7:0];
      OFS_SMI_HI:  bus_rdata = smi_pad[15:8];
      OFS_IRQ_LO:  bus_rdata = irq_pad[7:0];
      OFS_IRQ_HI:  bus_rdata = irq_pad[15:8];
      OFS_CRIT_LO: bus_rdata = crit_pad[7:0];
      OFS_CRIT_HI: bus_rdata = crit_pad[15:8];
      OFS_GCFG:    bus_rdata = {{(DW-1){1'b0}}, gen_q};
      OFS_BANK:    bus_rdata = bank_q;
      OFS_CCFG:    if (bank_ok) bus_rdata = {{(DW-1){1'b0}}, ch_en[bank_idx]};
      OFS_RDG:     if (bank_ok) bus_rdata = rdg_a[bank_idx];
      OFS_HI:      if (bank_ok) bus_rdata = hi_a[bank_idx];
      OFS_LO:      if (bank_ok) bus_rdata = lo_a[bank_idx];
      OFS_OT:      if (bank_ok) bus_rdata = ot_a[bank_idx];
      default:     bus_rdata = '0;
    endcase
  end

  // R2: an out-of-range bank exposes nothing
  assert_oob_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_ok && int'(bus_addr) >= OFS_CCFG && int'(bus_addr) <= OFS_OT) |-> bus_rdata == '0);
  // R3: at most one channel accepts a sample per cycle
  assert_one_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
endmodule

// File: tb/bank_limit_mon_test.sv
module bank_limit_mon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       smp_valid = 1'b0;
  logic [3:0] smp_chan = '0;
  logic [7:0] smp_value = '0;
  logic       sel_v = 1'b0;
  logic       probe = 1'b0;

  logic [7:0] rd_t, rd_v;
  logic smi_t, irq_t, crit_t, smi_v, irq_v, crit_v;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bank_limit_mon #(.NCH(3), .SIGNED_CMP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we & ~sel_v),
    .bus_wdata(bus_wdata), .bus_rdata(rd_t), .smp_valid(smp_valid & ~sel_v),
    .smp_chan(smp_chan[1:0]), .smp_value(smp_value),
    .smi_o(smi_t), .irq_o(irq_t), .crit_o(crit_t));

  bank_limit_mon #(.NCH(14), .SIGNED_CMP(1'b0)) uut_v (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we & sel_v),
    .bus_wdata(bus_wdata), .bus_rdata(rd_v), .smp_valid(smp_valid & sel_v),
    .smp_chan(smp_chan), .smp_value(smp_value),
    .smi_o(smi_v), .irq_o(irq_v), .crit_o(crit_v));

  typedef struct {
    bit         pins;
    bit         vinst;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];

  // Monitor: pops one expected item per probed cycle, mid-cycle
  always @(negedge clk) begin
    if (probe && sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      if (it.pins) act = it.vinst ? {5'b0, crit_v, irq_v, smi_v} : {5'b0, crit_t, irq_t, smi_t};
      else         act = it.vinst ? rd_v : rd_t;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input bit v, input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    sel_v = v; bus_addr = a; probe = 1'b1;
    it.pins = 1'b0; it.vinst = v; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  // expected pins as {crit, irq, smi}
  task automatic pins(input bit v, input logic [2:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    sel_v = v; probe = 1'b1;
    it.pins = 1'b1; it.vinst = v; it.exp = {5'b0, e}; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic wr(input bit v, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sel_v = v; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic smp(input bit v, input logic [3:0] ch, input logic [7:0] d);
    @(posedge clk); #1;
    sel_v = v; smp_chan = ch; smp_value = d; smp_valid = 1'b1;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic wr_smp(input logic [3:0] a, input logic [7:0] d, input logic [3:0] ch, input logic [7:0] s);
    @(posedge clk); #1;
    sel_v = 1'b0; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    smp_chan = ch; smp_value = s; smp_valid = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; smp_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R10 reset state
    rd(0, 4'h0, 8'h00, "R1 status");
    rd(0, 4'h8, 8'h00, "R1 global cfg");
    rd(0, 4'h9, 8'h00, "R1 bank");
    rd(0, 4'hA, 8'h00, "R1 chan enable");
    rd(0, 4'hC, 8'h7F, "R10 signed high");
    rd(0, 4'hD, 8'h80, "R10 signed low");
    rd(0, 4'hE, 8'h7F, "R10 signed crit");
    pins(0, 3'b000, "R1 outputs");
    rd(1, 4'hC, 8'hFF, "R10 unsigned high");
    rd(1, 4'hD, 8'h00, "R10 unsigned low");

    // R3 discards
    wr(0, 4'hA, 8'h01);
    smp(0, 4'd0, 8'h50);
    rd(0, 4'hB, 8'h00, "R3 global off keeps reading");
    rd(0, 4'h0, 8'h00, "R3 global off no event");
    wr(0, 4'h8, 8'h01);
    wr(0, 4'h9, 8'h01);
    smp(0, 4'd1, 8'h33);
    rd(0, 4'hB, 8'h00, "R3 disabled channel keeps reading");
    rd(0, 4'h0, 8'h00, "R3 disabled channel no event");

    // R4 / R5 / R6 window on channel 0: high 0x20, low 0xF0 (-16)
    wr(0, 4'h9, 8'h00);
    wr(0, 4'hC, 8'h20);
    wr(0, 4'hD, 8'hF0);
    smp(0, 4'd0, 8'h10);
    rd(0, 4'hB, 8'h10, "R4 reading stored");
    rd(0, 4'h0, 8'h00, "R6 signed 0x10 in window");
    smp(0, 4'd0, 8'h20);
    rd(0, 4'h0, 8'h00, "R6 equal high no event");
    smp(0, 4'd0, 8'hF0);
    rd(0, 4'h0, 8'h00, "R6 equal low no event");
    smp(0, 4'd0, 8'hF8);
    rd(0, 4'h0, 8'h00, "R6 signed -8 in window");
    smp(0, 4'd0, 8'h21);
    rd(0, 4'h0, 8'h01, "R5 above high");
    rd(0, 4'hB, 8'h21, "R4 reading updated");

    // R8 masks
    pins(0, 3'b000, "R8 masks empty");
    wr(0, 4'h2, 8'h01);
    pins(0, 3'b001, "R8 smi routed");
    wr(0, 4'h4, 8'h01);
    pins(0, 3'b011, "R8 irq routed");

    // R7 clear
    wr(0, 4'h0, 8'h01);
    rd(0, 4'h0, 8'h00, "R7 write one clears");
    pins(0, 3'b000, "R7 outputs drop");
    smp(0, 4'd0, 8'hE0);
    rd(0, 4'h0, 8'h01, "R5 below low");
    wr(0, 4'h0, 8'h00);
    rd(0, 4'h0, 8'h01, "R7 write zero keeps");
    wr_smp(4'h0, 8'h01, 4'd0, 8'h40);
    rd(0, 4'h0, 8'h01, "R7 set wins over clear");
    wr(0, 4'h0, 8'h01);
    rd(0, 4'h0, 8'h00, "R7 cleared again");

    // R9 critical limit
    wr(0, 4'hE, 8'h30);
    smp(0, 4'd0, 8'h31);
    rd(0, 4'h6, 8'h01, "R9 crit bit");
    rd(0, 4'h0, 8'h01, "R5 range bit with crit");
    pins(0, 3'b111, "R9 crit alert");
    wr(0, 4'h6, 8'h01);
    rd(0, 4'h6, 8'h00, "R9 crit cleared");
    pins(0, 3'b011, "R9 alert drops");
    wr(0, 4'h0, 8'h01);
    pins(0, 3'b000, "R7 all clear");

    // R2 bank select
    wr(0, 4'h9, 8'h05);
    rd(0, 4'h9, 8'h05, "R2 bank holds value");
    rd(0, 4'hA, 8'h00, "R2 oob cfg reads 0");
    rd(0, 4'hC, 8'h00, "R2 oob high reads 0");
    rd(0, 4'hB, 8'h00, "R2 oob reading reads 0");
    wr(0, 4'hC, 8'h11);
    wr(0, 4'h9, 8'h02);
    rd(0, 4'hC, 8'h7F, "R2 oob write ignored");
    wr(0, 4'h9, 8'h01);
    rd(0, 4'hC, 8'h7F, "R2 channel 1 separate");
    wr(0, 4'h9, 8'h00);
    rd(0, 4'hC, 8'h20, "R2 channel 0 kept");

    // channel 2 events and mask selectivity
    wr(0, 4'h9, 8'h02);
    wr(0, 4'hA, 8'h01);
    wr(0, 4'hD, 8'h00);
    rd(0, 4'hA, 8'h01, "R3 enable readback");
    smp(0, 4'd2, 8'hFF);
    rd(0, 4'h0, 8'h04, "R5 channel 2 bit");
    pins(0, 3'b000, "R8 other channel masked");
    wr(0, 4'h4, 8'h04);
    pins(0, 3'b010, "R8 irq only");
    smp(0, 4'd3, 8'h7F);
    rd(0, 4'h0, 8'h04, "R3 channel index out of range");
    wr(0, 4'hA, 8'h00);
    wr(0, 4'h0, 8'h04);
    smp(0, 4'd2, 8'h80);
    rd(0, 4'h0, 8'h00, "R3 disabled no event");
    rd(0, 4'hB, 8'hFF, "R3 disabled reading kept");

    // R11 unmapped
    rd(0, 4'hF, 8'h00, "R11 unassigned reads 0");
    rd(0, 4'h1, 8'h00, "R11 missing channels read 0");
    wr(0, 4'hF, 8'hAA);
    rd(0, 4'hF, 8'h00, "R11 unassigned write ignored");

    // voltage build: unsigned, 14 channels
    wr(1, 4'h8, 8'h01);
    wr(1, 4'h9, 8'h0C);
    wr(1, 4'hA, 8'h01);
    wr(1, 4'hC, 8'hA0);
    wr(1, 4'hD, 8'h10);
    smp(1, 4'd12, 8'h90);
    rd(1, 4'hB, 8'h90, "R4 voltage reading");
    rd(1, 4'h1, 8'h00, "R6 unsigned 0x90 in window");
    smp(1, 4'd12, 8'hB0);
    rd(1, 4'h1, 8'h10, "R5 channel 12 in upper byte");
    rd(1, 4'h0, 8'h00, "R5 lower byte untouched");
    wr(1, 4'h5, 8'h10);
    pins(1, 3'b010, "R8 upper irq mask");
    wr(1, 4'h1, 8'h10);
    pins(1, 3'b000, "R7 upper byte clear");

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule